// File: doc/BRIEF.md
# Miscellaneous Control Register with Atomic Update Aliases

This block holds one 64-bit control/status word behind a simple synchronous register bus. Software can overwrite the word, or change it in place without a read-modify-write sequence by writing to alias word offsets. One alias merges the write data in with a bitwise OR. The other alias either keeps only the bits set in both the stored value and the write data (bitwise AND), or clears the whole word; a parameter picks which. Only the upper 16 bits of the word are implemented. The most significant bit drives a level interrupt line.

A parameter selects one of two address maps. Each map places the direct offset and its two aliases at three consecutive word offsets. The word offset is the byte address shifted right by three. Every access is a full 8-byte word, and bit 63 is the most significant bit of the big-endian word. Any access to an offset outside the three mapped ones raises a one-cycle unimplemented-access pulse.

Top module: `misc_alias_reg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the stored word is zero and `irq_out`, `rd_data` and `unimp_pulse` are all 0.
- R2: A write to the direct offset (0x4020 when `MAP_SEL`=0, 0x6080 when `MAP_SEL`=1) stores the write data with bits 47:0 forced to zero. The new value is visible from the next cycle.
- R3: With `MAP_SEL`=0, a write to offset 0x4021 stores (current AND write data), masked to bits 63:48.
- R4: With `MAP_SEL`=1, a write to offset 0x6081 sets the stored word to zero, whatever the write data.
- R5: A write to the OR alias (0x4022 for `MAP_SEL`=0, 0x6082 for `MAP_SEL`=1) stores (current OR write data), masked to bits 63:48.
- R6: Bits 47:0 of the stored word always read as zero.
- R7: `irq_out` equals bit 63 of the stored word, from the cycle after each write. A write that leaves bit 63 unchanged leaves `irq_out` unchanged.
- R8: `rd_data` is registered. One cycle after a read of the direct offset it holds the stored value. One cycle after a read of any other offset, the alias offsets included, or after a cycle with `rd_en` low, it holds zero.
- R9: A write to any offset other than the three mapped ones leaves the stored word and `irq_out` unchanged.
- R10: `unimp_pulse` is 1 for exactly the cycle after a cycle in which `wr_en` or `rd_en` was high with an unmapped offset, and 0 otherwise.
- R11: When a read and a write of the direct offset fall in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_addr | input | ADDR_W | Word offset (byte address >> 3) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data, bit 63 is the most significant bit |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Registered read data |
| irq_out | output | 1 | Level interrupt, bit 63 of the stored word |
| unimp_pulse | output | 1 | One-cycle flag for an access to an unmapped offset |

## Verification
On every cycle, the embedded properties check the result of each kind of write: direct, AND or clear alias, and OR alias. They also check that unmapped writes change nothing, that read data is zero for non-direct reads, that the low bits of read data stay zero, and that the unimplemented pulse follows the access that caused it. Other behaviour shows up only in the bench's scenarios, which run a model of both address maps side by side on the same bus. That covers the read-during-write ordering, interrupt behaviour across writes that keep bit 63 unchanged, accesses meant for one map landing on the other map's offsets, and long mixed sequences of aliased updates.

// File: rtl/misc_alias_reg.sv
module misc_alias_reg #(
  parameter bit MAP_SEL = 1'b0,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 64,
  parameter int KEEP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out,
  output logic              unimp_pulse
);
  localparam logic [ADDR_W-1:0] BASE_OFS = ADDR_W'(MAP_SEL ? 32'h6080 : 32'h4020);
  localparam logic [ADDR_W-1:0] LOW_OFS  = BASE_OFS + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OR_OFS   = BASE_OFS + ADDR_W'(2);
  localparam logic [DATA_W-1:0] KEEP_MSK = {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  logic [DATA_W-1:0] misc_q, misc_nx;
  logic hit_dir, hit_low, hit_or, mapped;

  assign hit_dir = word_addr == BASE_OFS;
  assign hit_low = word_addr == LOW_OFS;
  assign hit_or  = word_addr == OR_OFS;
  assign mapped  = hit_dir | hit_low | hit_or;

  always_comb begin
    misc_nx = misc_q;
    if (wr_en) begin
      if (hit_dir)      misc_nx = wr_data;
      else if (hit_low) misc_nx = MAP_SEL ? '0 : (misc_q & wr_data);
      else if (hit_or)  misc_nx = misc_q | wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q      <= '0;
      rd_data     <= '0;
      unimp_pulse <= 1'b0;
    end else begin
      misc_q      <= misc_nx & KEEP_MSK;
      rd_data     <= (rd_en && hit_dir) ? misc_q : '0;
      unimp_pulse <= (wr_en || rd_en) && !mapped;
    end
  end

  assign irq_out = misc_q[DATA_W-1];

  // R2 R7
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dir) |=> (misc_q == ($past(wr_data) & KEEP_MSK)) && (irq_out == $past(wr_data[DATA_W-1])));

  // R5
  or_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_or) |=> misc_q == (($past(misc_q) | $past(wr_data)) & KEEP_MSK));

  generate
    if (MAP_SEL) begin : g_clear
      // R4
      clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_low) |=> (misc_q == '0) && !irq_out);
    end else begin : g_and
      // R3
      and_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_low) |=> misc_q == (($past(misc_q) & $past(wr_data)) & KEEP_MSK));
    end
  endgenerate

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(misc_q) && $stable(irq_out));

  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && hit_dir) |=> rd_data == '0);

  // R6
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-KEEP_W-1:0] == '0);

  // R10
  unimp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> unimp_pulse == $past((wr_en || rd_en) && !mapped));
endmodule

// File: tb/misc_alias_reg_tb.sv
module misc_alias_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] word_addr = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [63:0] rd_a, rd_b;
  logic        irq_a, irq_b, un_a, un_b;

  always #5 clk = ~clk;

  misc_alias_reg #(.MAP_SEL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_a), .irq_out(irq_a),
    .unimp_pulse(un_a));

  misc_alias_reg #(.MAP_SEL(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_b), .irq_out(irq_b),
    .unimp_pulse(un_b));

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  bit checking = 0;
  string cur_tag = "R1";
  string ref_tag = "R1";
  logic [63:0] m_reg [2];
  logic [63:0] m_rd  [2];
  logic        m_un  [2];
  localparam logic [63:0] TOP16 = 64'hFFFF_0000_0000_0000;

  always @(posedge clk) begin
    ref_tag <= cur_tag;
    for (int v = 0; v < 2; v++) begin
      int base;
      base = (v == 0) ? 'h4020 : 'h6080;
      if (!rst_n) begin
        m_reg[v] = '0; m_rd[v] = '0; m_un[v] = 1'b0;
      end else begin
        m_rd[v] = (rd_en && word_addr == 20'(base)) ? m_reg[v] : 64'd0;
        m_un[v] = (rd_en || wr_en) && !(word_addr == 20'(base) ||
                  word_addr == 20'(base + 1) || word_addr == 20'(base + 2));
        if (wr_en) begin
          if (word_addr == 20'(base)) m_reg[v] = wr_data & TOP16;
          else if (word_addr == 20'(base + 1))
            m_reg[v] = (v == 1) ? 64'd0 : (m_reg[v] & wr_data & TOP16);
          else if (word_addr == 20'(base + 2)) m_reg[v] = (m_reg[v] | wr_data) & TOP16;
        end
      end
    end
  end

  task automatic cmp64(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", ref_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      cmp64("map0 rd_data (R8)", rd_a, m_rd[0]);
      cmp64("map1 rd_data (R8)", rd_b, m_rd[1]);
      cmp64("map0 irq_out (R7)", {63'd0, irq_a}, {63'd0, m_reg[0][63]});
      cmp64("map1 irq_out (R7)", {63'd0, irq_b}, {63'd0, m_reg[1][63]});
      cmp64("map0 unimp_pulse (R10)", {63'd0, un_a}, {63'd0, m_un[0]});
      cmp64("map1 unimp_pulse (R10)", {63'd0, un_b}, {63'd0, m_un[1]});
    end
  end

  task automatic op(string tag, int addr, bit we, bit re, logic [63:0] wd);
    @(negedge clk);
    cur_tag = tag;
    word_addr = 20'(addr);
    wr_en = we;
    rd_en = re;
    wr_data = wd;
  endtask

  task automatic idle();
    op(cur_tag, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs are zero during reset
    ref_tag = "R1";
    vectors++;
    if ({rd_a, rd_b} !== '0 || {irq_a, irq_b, un_a, un_b} !== 4'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %h %h %b expected 0", rd_a, rd_b, {irq_a, irq_b, un_a, un_b});
    end
    rst_n = 1'b1;
    checking = 1'b1;
    op("R1", 'h4020, 0, 1, '0);
    op("R1", 'h6080, 0, 1, '0);
    // R2 R6: direct write keeps only the top 16 bits
    op("R2", 'h4020, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R6", 'h4020, 0, 1, '0);
    op("R2", 'h6080, 1, 0, 64'h8001_2345_6789_ABCD);
    op("R6", 'h6080, 0, 1, '0);
    // R3: AND alias on map 0
    op("R3", 'h4021, 1, 0, 64'h0F0F_FFFF_0000_0000);
    op("R3", 'h4020, 0, 1, '0);
    // R7: same value rewritten, irq keeps its level
    op("R7", 'h6080, 1, 0, 64'h8001_0000_0000_0000);
    op("R7", 'h6082, 1, 0, 64'h8000_0000_0000_0000);
    // R5: OR alias raises irq on map 0
    op("R5", 'h4022, 1, 0, 64'h8000_0000_0000_0001);
    op("R5", 'h4020, 0, 1, '0);
    // R4: clear alias on map 1 ignores the data; unmapped on map 0
    op("R4", 'h6081, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R4", 'h6080, 0, 1, '0);
    // R8: alias reads return zero
    op("R8", 'h4021, 0, 1, '0);
    op("R8", 'h4022, 0, 1, '0);
    op("R8", 'h6082, 0, 1, '0);
    // R9 R10: unmapped write and read
    op("R9", 'h1234, 1, 0, 64'h0000_0000_0000_0000);
    op("R10", 'h4023, 0, 1, '0);
    op("R9", 'h4020, 0, 1, '0);
    // R11: read and write of the direct offset in one cycle
    op("R11", 'h4020, 1, 1, 64'h1234_0000_0000_0000);
    op("R11", 'h4020, 0, 1, '0);
    op("R11", 'h6080, 1, 1, 64'hC000_0000_0000_0000);
    op("R11", 'h6080, 0, 1, '0);
    // R3 R4 R5: mixed traffic over both maps
    for (int i = 0; i < 400; i++) begin
      int sel;
      int a;
      sel = int'($urandom_range(0, 8));
      case (sel)
        0: a = 'h4020; 1: a = 'h4021; 2: a = 'h4022;
        3: a = 'h6080; 4: a = 'h6081; 5: a = 'h6082;
        6: a = 'h401F; 7: a = 'h6083;
        default: a = int'($urandom_range(0, 'hFFFFF));
      endcase
      op("R3/R4/R5 mix", a, 1'($urandom), 1'($urandom), {$urandom, $urandom});
    end
    idle();
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule